// File: doc/BRIEF.md
# Single-Hall Bridge Commutation and Stall Recovery Controller

This block holds the digital drive decisions for a small two-phase, single-direction brushless motor (a fan or a vibration motor) that sits across a full H-bridge. Once per clock it compares a signed field sample from one Hall sensor against an upper and a lower switch point. The hysteretic result chooses which diagonal of the bridge conducts. The two diagonals are never on together, and a short all-off gap is always placed between them.

When the field polarity stops alternating, the controller declares a stall and starts a recovery cycle. The bridge is switched off and on in fixed-length phases until the rotor moves again. A low-active sleep input switches the bridge off, clears the Hall decision and holds the logic idle. After wake-up the Hall result is ignored for a settling window. A fault input, which another block derives from thermal or short-circuit sensing, blanks the bridge at once. Drive comes back one recovery period after that input clears.

All timing is set in microseconds and converted to clock cycles from the `CLK_HZ` parameter. The dead time is given directly in cycles.

Top module: `hcCommutator`

## Requirements
- R1: With the field sample above `OP_THR`, the block drives the diagonal Q1+Q4: `gateEn` = 4'b1001 (bit0 Q1 high side of output 1, bit1 Q2 low side of output 1, bit2 Q3 high side of output 2, bit3 Q4 low side of output 2), with `out1Lvl`=1 and `out2Lvl`=0.
- R2: With the field sample below `RP_THR`, the block drives the diagonal Q2+Q3: `gateEn` = 4'b0110, with `out1Lvl`=0 and `out2Lvl`=1.
- R3: A field sample between the two thresholds (inclusive) leaves the last decided polarity and its diagonal unchanged.
- R4: `gateEn` only ever takes the values 4'b0000, 4'b1001 or 4'b0110. While a diagonal is on, the two output levels differ. With all switches off, both levels read 0. After reset the gates are off.
- R5: While `sleepN` is 0, all four gates are off within the same cycle, and the Hall decision is forgotten.
- R6: After `sleepN` rises, no gate turns on for at least the settle time. The first diagonal driven depends only on the field polarity against the thresholds. A field that stays between the thresholds after wake-up drives nothing.
- R7: Every change from one diagonal to the other passes through at least `DEAD_CYC` cycles with all gates off.
- R8: If no polarity change occurs for the stall timeout while a diagonal is driven, all gates turn off.
- R9: After a stall, the gates alternate between off and on in phases of one restart period each. Each on phase drives the diagonal of the current polarity.
- R10: A polarity change during the off or on phase of a restart ends the stall recovery. Normal commutation then follows the field with no further off/on cycling.
- R11: With `faultIn` at 1, all gates are off in the same cycle. Drive resumes one restart period after `faultIn` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleepN | input | 1 | 0 = sleep (bridge off, idle), 1 = enabled |
| faultIn | input | 1 | 1 = thermal or short-circuit fault; bridge blanked |
| fieldIn | input | FIELD_W | Signed Hall field sample (gauss units) |
| gateEn | output | 4 | Gate enables {Q4,Q3,Q2,Q1} |
| out1Lvl | output | 1 | Logical level of output 1 (1 = pulled high) |
| out2Lvl | output | 1 | Logical level of output 2 (1 = pulled high) |

## Verification
The checker watches four things on every clock edge:
- the gate encoding stays in the legal set;
- the output levels are complementary whenever a diagonal is on;
- the bridge is off under sleep and under fault;
- no diagonal ever follows the other without an all-off cycle between them, and nothing is driven inside the settle window after wake-up.

The exact lengths of the stall timeout, the restart phases, the dead gap and the post-fault hold can only be shown by the bench's timed scenarios, and so can the choice of diagonal under hysteresis. The bench's random field sequences are checked against a hysteresis model of its own.

// File: rtl/hcPkg.sv
package hcPkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_SETTLE = 3'd1,
    ST_ARM    = 3'd2,
    ST_RUN    = 3'd3,
    ST_DEAD   = 3'd4,
    ST_RSTOFF = 3'd5,
    ST_RSTON  = 3'd6,
    ST_FAULT  = 3'd7
  } hcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerClr;  // restart the phase timer
    logic hallClr;   // forget the Hall decision
    logic loadDiag;  // latch the current polarity as the driven diagonal
    logic driveEn;   // bridge on in the next cycle
  } hcStrobe_t;

  // diag 1 -> Q1+Q4, diag 0 -> Q2+Q3 ; bit order {Q4,Q3,Q2,Q1}
  function automatic logic [3:0] diagPattern(input logic diag);
    return diag ? 4'b1001 : 4'b0110;
  endfunction

endpackage

// File: rtl/hcDatapath.sv
module hcDatapath
  import hcPkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int OP_THR  = 35,
  parameter int RP_THR  = -35,
  parameter int TW      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  hcStrobe_t                 strobe,
  input  logic signed [FIELD_W-1:0] fieldIn,
  output logic                      pol,
  output logic                      polValid,
  output logic                      polFlip,
  output logic                      driveDiag,
  output logic [TW-1:0]             timer,
  output logic [3:0]                gateRaw
);

  localparam logic signed [FIELD_W-1:0] OP_V = FIELD_W'(OP_THR);
  localparam logic signed [FIELD_W-1:0] RP_V = FIELD_W'(RP_THR);
  localparam logic [TW-1:0]             TMAX = {TW{1'b1}};

  logic aboveOp;
  logic belowRp;
  logic nextPol;
  logic selDiag;

  always_comb begin
    aboveOp = fieldIn > OP_V;
    belowRp = fieldIn < RP_V;
    if (aboveOp)      nextPol = 1'b1;
    else if (belowRp) nextPol = 1'b0;
    else              nextPol = pol;
    selDiag = strobe.loadDiag ? pol : driveDiag;
  end

  // Hysteretic polarity decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol      <= 1'b0;
      polValid <= 1'b0;
      polFlip  <= 1'b0;
    end else if (strobe.hallClr) begin
      polValid <= 1'b0;
      polFlip  <= 1'b0;
    end else begin
      polFlip  <= polValid && (nextPol != pol);
      pol      <= nextPol;
      polValid <= polValid | aboveOp | belowRp;
    end
  end

  // Phase timer, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                timer <= '0;
    else if (strobe.timerClr)  timer <= '0;
    else if (timer != TMAX)    timer <= timer + 1'b1;
  end

  // Driven diagonal and registered gate pattern
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      driveDiag <= 1'b0;
      gateRaw   <= 4'b0000;
    end else begin
      driveDiag <= selDiag;
      gateRaw   <= strobe.driveEn ? diagPattern(selDiag) : 4'b0000;
    end
  end

endmodule

// File: rtl/hcControl.sv
module hcControl
  import hcPkg::*;
#(
  parameter int TW          = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int STALL_CYC   = 100,
  parameter int RESTART_CYC = 50,
  parameter int DEAD_CYC    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleepN,
  input  logic          faultIn,
  input  logic          pol,
  input  logic          polValid,
  input  logic          polFlip,
  input  logic          driveDiag,
  input  logic [TW-1:0] timer,
  output hcStrobe_t     strobe
);

  localparam logic [TW-1:0] SETTLE_END  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] STALL_END   = TW'(STALL_CYC - 1);
  localparam logic [TW-1:0] RESTART_END = TW'(RESTART_CYC - 1);
  localparam logic [TW-1:0] DEAD_END    = TW'(DEAD_CYC - 1);

  hcState_t st, nextSt;
  logic     load, drive;

  always_comb begin
    nextSt = st;
    load   = 1'b0;
    drive  = 1'b0;
    unique case (st)
      ST_SLEEP:  nextSt = ST_SETTLE;
      ST_SETTLE: if (timer == SETTLE_END) nextSt = ST_ARM;
      ST_ARM: if (polValid) begin
        nextSt = ST_RUN; load = 1'b1; drive = 1'b1;
      end
      ST_RUN: begin
        if (pol != driveDiag)       nextSt = ST_DEAD;
        else if (timer == STALL_END) nextSt = ST_RSTOFF;
        else                         drive  = 1'b1;
      end
      ST_DEAD: if (timer == DEAD_END) begin
        nextSt = ST_RUN; load = 1'b1; drive = 1'b1;
      end
      ST_RSTOFF: begin
        if (polFlip) begin
          nextSt = ST_RUN; load = 1'b1; drive = 1'b1;
        end else if (timer == RESTART_END) begin
          nextSt = ST_RSTON; load = 1'b1; drive = 1'b1;
        end
      end
      ST_RSTON: begin
        if (polFlip)                   nextSt = ST_DEAD;
        else if (timer == RESTART_END) nextSt = ST_RSTOFF;
        else                           drive  = 1'b1;
      end
      ST_FAULT: begin
        if (!faultIn && timer == RESTART_END) begin
          if (polValid) begin
            nextSt = ST_RUN; load = 1'b1; drive = 1'b1;
          end else begin
            nextSt = ST_ARM;
          end
        end
      end
      default: nextSt = ST_SLEEP;
    endcase

    // Overrides: sleep first, then fault
    if (!sleepN) begin
      nextSt = ST_SLEEP; load = 1'b0; drive = 1'b0;
    end else if (faultIn && st != ST_SLEEP) begin
      nextSt = ST_FAULT; load = 1'b0; drive = 1'b0;
    end

    strobe.timerClr = (nextSt != st) || (st == ST_FAULT && faultIn);
    strobe.hallClr  = (nextSt == ST_SLEEP) || (nextSt == ST_SETTLE);
    strobe.loadDiag = load;
    strobe.driveEn  = drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_SLEEP;
    else        st <= nextSt;
  end

endmodule

// File: rtl/hcCommutator.sv
module hcCommutator
  import hcPkg::*;
#(
  parameter int FIELD_W    = 10,
  parameter int OP_THR     = 35,
  parameter int RP_THR     = -35,
  parameter int CLK_HZ     = 50_000_000,
  parameter int SETTLE_US  = 80,
  parameter int STALL_US   = 120_000,
  parameter int RESTART_US = 120_000,
  parameter int DEAD_CYC   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleepN,
  input  logic               faultIn,
  input  logic [FIELD_W-1:0] fieldIn,
  output logic [3:0]         gateEn,
  output logic               out1Lvl,
  output logic               out2Lvl
);

  localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
  localparam int SETTLE_CYC  = (CYC_PER_US * SETTLE_US  > 0) ? CYC_PER_US * SETTLE_US  : 1;
  localparam int STALL_CYC   = (CYC_PER_US * STALL_US   > 0) ? CYC_PER_US * STALL_US   : 1;
  localparam int RESTART_CYC = (CYC_PER_US * RESTART_US > 0) ? CYC_PER_US * RESTART_US : 1;
  localparam int DEAD_LEN    = (DEAD_CYC > 0) ? DEAD_CYC : 1;
  localparam int MAX_A       = (STALL_CYC > RESTART_CYC) ? STALL_CYC : RESTART_CYC;
  localparam int MAX_B       = (SETTLE_CYC > DEAD_LEN) ? SETTLE_CYC : DEAD_LEN;
  localparam int MAX_CYC     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW          = $clog2(MAX_CYC + 1);

  hcStrobe_t     strobe;
  logic          pol, polValid, polFlip, driveDiag;
  logic [TW-1:0] timer;
  logic [3:0]    gateRaw;

  hcControl #(
    .TW(TW), .SETTLE_CYC(SETTLE_CYC), .STALL_CYC(STALL_CYC),
    .RESTART_CYC(RESTART_CYC), .DEAD_CYC(DEAD_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleepN(sleepN), .faultIn(faultIn),
    .pol(pol), .polValid(polValid), .polFlip(polFlip),
    .driveDiag(driveDiag), .timer(timer), .strobe(strobe)
  );

  hcDatapath #(
    .FIELD_W(FIELD_W), .OP_THR(OP_THR), .RP_THR(RP_THR), .TW(TW)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fieldIn($signed(fieldIn)),
    .pol(pol), .polValid(polValid), .polFlip(polFlip),
    .driveDiag(driveDiag), .timer(timer), .gateRaw(gateRaw)
  );

  // Sleep and fault blank the bridge without waiting for a clock edge
  always_comb begin
    gateEn  = (sleepN && !faultIn) ? gateRaw : 4'b0000;
    out1Lvl = gateEn[0];
    out2Lvl = gateEn[2];
  end

endmodule

// File: rtl/hcChecker.sv
module hcChecker #(
  parameter int SETTLE_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleepN,
  input logic       faultIn,
  input logic [3:0] gateEn,
  input logic       out1Lvl,
  input logic       out2Lvl
);

  localparam int CW = $clog2(SETTLE_CYC + 2);
  logic [CW-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wakeCnt <= '0;
    else if (!sleepN)                 wakeCnt <= '0;
    else if (wakeCnt < CW'(SETTLE_CYC)) wakeCnt <= wakeCnt + 1'b1;
  end

  a_r4_legal_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn == 4'b0000) || (gateEn == 4'b1001) || (gateEn == 4'b0110));

  a_r4_levels_differ: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn != 4'b0000) |-> (out1Lvl != out2Lvl));

  a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sleepN |-> (gateEn == 4'b0000));

  a_r11_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    faultIn |-> (gateEn == 4'b0000));

  a_r7_gap_between_diagonals: assert property (@(posedge clk) disable iff (!rst_n)
    ((gateEn != 4'b0000) && ($past(gateEn) != 4'b0000)) |-> (gateEn == $past(gateEn)));

  a_r6_settle_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEn != 4'b0000) |-> (wakeCnt >= CW'(SETTLE_CYC)));

endmodule

bind hcCommutator hcChecker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleepN(sleepN), .faultIn(faultIn),
  .gateEn(gateEn), .out1Lvl(out1Lvl), .out2Lvl(out2Lvl)
);

// File: tb/hcCommutator_tb.sv
module hcCommutator_tb;

  localparam int FW      = 10;
  localparam int SETTLE  = 16;   // cycles (CLK_HZ = 1 MHz => 1 cycle per us)
  localparam int STALL   = 400;
  localparam int RESTART = 200;
  localparam int DEAD    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleepN = 1'b0;
  logic          faultIn = 1'b0;
  logic [FW-1:0] fieldIn = '0;
  logic [3:0]    gateEn;
  logic          out1Lvl, out2Lvl;

  int testCnt = 0;
  int failCnt = 0;
  int cycCnt  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  hcCommutator #(
    .FIELD_W(FW), .OP_THR(35), .RP_THR(-35), .CLK_HZ(1_000_000),
    .SETTLE_US(SETTLE), .STALL_US(STALL), .RESTART_US(RESTART), .DEAD_CYC(DEAD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sleepN(sleepN), .faultIn(faultIn),
    .fieldIn(fieldIn), .gateEn(gateEn), .out1Lvl(out1Lvl), .out2Lvl(out2Lvl)
  );

  function automatic logic [3:0] expPattern(input bit p);
    return p ? 4'b1001 : 4'b0110;
  endfunction

  function automatic bit hyst(input int f, input bit prev);
    if (f > 35)  return 1'b1;
    if (f < -35) return 1'b0;
    return prev;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setField(input int f);
    fieldIn = FW'(f);
  endtask

  // number of cycles until gateEn differs from 'cur' (bounded)
  task automatic runLen(input logic [3:0] cur, input int lim, output int len);
    len = 0;
    while (gateEn == cur && len < lim) begin
      @(negedge clk);
      len++;
    end
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt > 150_000 && !done) begin
      done = 1'b1;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycCnt, 150_000);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int len, zeros;
    bit expPol;
    int since;
    void'($urandom(32'd20250611));

    // reset state (R4)
    cyc(3);
    check(gateEn == 4'b0000 && !out1Lvl && !out2Lvl, "R4 reset off", gateEn, 0);
    rst_n = 1'b1;

    // R5: sleep holds bridge off even with strong field
    setField(100);
    cyc(40);
    check(gateEn == 4'b0000, "R5 sleep off", gateEn, 0);

    // R6: wake with field inside the band -> nothing driven
    setField(0);
    sleepN = 1'b1;
    cyc(60);
    check(gateEn == 4'b0000, "R6 no polarity no drive", gateEn, 0);

    // R6: wake with positive field, blank then drive
    sleepN = 1'b0; cyc(2);
    setField(100);
    sleepN = 1'b1;
    cyc(8);
    check(gateEn == 4'b0000, "R6 settle blank", gateEn, 0);
    cyc(22);
    check(gateEn == 4'b1001 && out1Lvl && !out2Lvl, "R1 positive field Q1+Q4", gateEn, 9);

    // R3: inside band keeps diagonal
    setField(20); cyc(20);
    check(gateEn == 4'b1001, "R3 hold high", gateEn, 9);

    // R2 / R7: flip to negative, count the dead gap
    setField(-100);
    cyc(2);
    zeros = 0;
    for (int i = 0; i < 20; i++) begin
      if (gateEn == 4'b0000) zeros++;
      if (gateEn == 4'b0110) break;
      @(negedge clk);
    end
    check(zeros >= DEAD && zeros <= DEAD + 3, "R7 dead gap", zeros, DEAD);
    check(gateEn == 4'b0110 && !out1Lvl && out2Lvl, "R2 negative field Q2+Q3", gateEn, 6);
    setField(-20); cyc(20);
    check(gateEn == 4'b0110, "R3 hold low", gateEn, 6);

    // R8: stall after flip to positive
    setField(100);
    runLen(4'b0110, 30, len);
    runLen(4'b0000, 30, len);
    check(gateEn == 4'b1001, "R1 commutate positive", gateEn, 9);
    runLen(4'b1001, STALL + 50, len);
    check(len >= STALL - 4 && len <= STALL + 2, "R8 stall timeout", len, STALL);
    check(gateEn == 4'b0000, "R8 off after stall", gateEn, 0);
    runLen(4'b0000, RESTART + 50, len);
    check(len >= RESTART - 3 && len <= RESTART + 3, "R9 restart off phase", len, RESTART);
    check(gateEn == 4'b1001, "R9 on phase follows polarity", gateEn, 9);
    runLen(4'b1001, RESTART + 50, len);
    check(len >= RESTART - 3 && len <= RESTART + 3, "R9 restart on phase", len, RESTART);

    // R10: flip during off phase returns to commutation
    cyc(50);
    check(gateEn == 4'b0000, "R9 second off phase", gateEn, 0);
    setField(-100);
    cyc(6);
    check(gateEn == 4'b0110, "R10 flip ends recovery", gateEn, 6);
    setField(-20);
    cyc(150);
    check(gateEn == 4'b0110, "R10 no cycling after recovery", gateEn, 6);

    // R11: fault blanks immediately, resumes after restart period
    faultIn = 1'b1;
    #1;
    check(gateEn == 4'b0000, "R11 fault immediate", gateEn, 0);
    cyc(30);
    check(gateEn == 4'b0000, "R11 fault held", gateEn, 0);
    faultIn = 1'b0;
    cyc(RESTART - 30);
    check(gateEn == 4'b0000, "R11 hold after clear", gateEn, 0);
    cyc(40);
    check(gateEn == 4'b0110, "R11 resume", gateEn, 6);

    // R5: sleep during drive
    sleepN = 1'b0;
    #1;
    check(gateEn == 4'b0000 && !out1Lvl && !out2Lvl, "R5 sleep immediate", gateEn, 0);
    cyc(5);

    // Random field sequences against a hysteresis model (R1 R2 R3 R4)
    setField(100);
    sleepN = 1'b1;
    cyc(40);
    expPol = 1'b1;
    since = 0;
    check(gateEn == 4'b1001, "R6 wake drive", gateEn, 9);
    for (int s = 0; s < 200; s++) begin
      int f, n;
      bit np;
      f = int'($urandom_range(0, 240)) - 120;
      n = int'($urandom_range(12, 60));
      if (since > 250) f = expPol ? -100 : 100;
      np = hyst(f, expPol);
      if (np != expPol) since = n; else since += n;
      expPol = np;
      setField(f);
      cyc(n);
      check(gateEn == expPattern(expPol) && out1Lvl == expPol && out2Lvl == !expPol,
            expPol ? "R1 R3 random" : "R2 R3 random", gateEn, expPattern(expPol));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule